// File: doc/BRIEF.md
# Modem Line Control and Status Register Pair

This block holds the serial port's modem control register and builds its modem status register. Software writes the control register to drive four handshake outputs (data terminal ready, request to send and two general-purpose outputs) and to select an internal loopback. The four modem inputs (clear to send, data set ready, ring indicator and carrier detect) pass through a synchronizer. Every change on an input is latched as a sticky change flag. Any latched flag raises a modem-status interrupt request.

Reading the status register returns the synchronized input levels in the upper nibble and the change flags in the lower nibble. Outside loopback, the read clears the change flags after the cycle in which the data was presented. In loopback, the status register instead shows the control register's four output bits, moved into the input positions, so software can test the handshake path without a cable. The inputs are all active high, with 1 meaning the line is asserted.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset the control register reads 0x08, the status register reads 0xB0 (carrier detect, data set ready and clear to send asserted, ring low, no change flags), dtr_o, rts_o and out1_o are 0, out2_o is 1 and msi_o is 0.
- R2: A control register write keeps write-data bits 4:0, and bits 7:5 of mcr_o read 0.
- R3: dtr_o, rts_o, out1_o and out2_o follow control bits 0, 1, 2 and 3 respectively.
- R4: Outside loopback (control bit 4 = 0), status bits 7:4 show the synchronized {dcd_i, ri_i, dsr_i, cts_i}. A pin change becomes visible after the second rising edge.
- R5: A change in either direction on cts_i, dsr_i or dcd_i sets status bit 0, 1 or 3 respectively on the third rising edge after the change.
- R6: Status bit 2 is set only by a 1-to-0 transition of ri_i. A 0-to-1 transition leaves it unchanged.
- R7: A status read (msr_re_i = 1 for one cycle) outside loopback returns the current value and then clears bits 3:0. Bits 7:4 are unchanged.
- R8: When a new change event and a clearing read meet on the same edge, the new event's flag ends up set and the other flags are cleared.
- R9: In loopback the status read value is {mcr[3], mcr[2], mcr[0], mcr[1], 4'b0000}.
- R10: A status read in loopback clears no change flag. Changes on the input pins during loopback are still recorded, and they are visible once loopback is left.
- R11: msi_o is 1 exactly when at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mcr_we_i | input | 1 | Control register write strobe |
| mcr_wdata_i | input | 8 | Control register write data |
| msr_re_i | input | 1 | Status register read strobe |
| cts_i | input | 1 | Clear-to-send pin, asynchronous |
| dsr_i | input | 1 | Data-set-ready pin, asynchronous |
| ri_i | input | 1 | Ring indicator pin, asynchronous |
| dcd_i | input | 1 | Carrier detect pin, asynchronous |
| mcr_o | output | 8 | Control register value |
| msr_rdata_o | output | 8 | Status register read value |
| dtr_o | output | 1 | Data terminal ready output |
| rts_o | output | 1 | Request to send output |
| out1_o | output | 1 | General-purpose output 1 |
| out2_o | output | 1 | General-purpose output 2 |
| msi_o | output | 1 | Modem-status interrupt request |

## Verification
The assertions check the following on every cycle:
- the zero upper control bits;
- the loopback mapping;
- that the interrupt agrees with the visible flags outside loopback;
- that a clearing read leaves only same-edge events behind;
- that a ring flag can only be raised by a falling level.

Only the bench scenarios can show the following:
- the exact latency from pin to status bit and to flag;
- the collision of a read with an arriving edge;
- that flags survive a loopback read and reappear when loopback is left;
- the reset values.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned PIN_N   = 4;
  localparam int unsigned MCR_W   = 5;
  // pin/flag index: 0 cts, 1 dsr, 2 ri, 3 dcd
  localparam int unsigned IDX_CTS = 0;
  localparam int unsigned IDX_DSR = 1;
  localparam int unsigned IDX_RI  = 2;
  localparam int unsigned IDX_DCD = 3;
  localparam int unsigned LOOP_BIT = 4;
  localparam logic [PIN_N-1:0] PIN_RST  = 4'b1011;
  localparam logic [PIN_N-1:0] FALL_MSK = 4'b0100;
  localparam logic [MCR_W-1:0] MCR_RST  = 5'b01000;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/modem_delta.sv
module modem_delta #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL  = '0,
  parameter logic [W-1:0] FALL_MSK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sts_i,
  input  logic         clr_i,
  output logic [W-1:0] prev_o,
  output logic [W-1:0] set_o,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] prev_q, flag_q, set_w;

  for (genvar i = 0; i < W; i++) begin : g_edge
    if (FALL_MSK[i]) begin : g_fall
      assign set_w[i] = prev_q[i] & ~sts_i[i];
    end else begin : g_any
      assign set_w[i] = prev_q[i] ^ sts_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= RST_VAL;
      flag_q <= '0;
    end else begin
      prev_q <= sts_i;
      // a fresh event wins over a same-edge clear
      flag_q <= (clr_i ? '0 : flag_q) | set_w;
    end
  end

  assign prev_o = prev_q;
  assign set_o  = set_w;
  assign flag_o = flag_q;
endmodule

// File: rtl/modem_mcr.sv
module modem_mcr #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned KEEP_W = 5,
  parameter logic [KEEP_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] mcr_o
);
  logic [KEEP_W-1:0] mcr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mcr_q <= RST_VAL;
    else if (we_i) mcr_q <= wdata_i[KEEP_W-1:0];
  end

  assign mcr_o = {{(REG_W-KEEP_W){1'b0}}, mcr_q};
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import modem_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mcr_we_i,
  input  logic [REG_W-1:0] mcr_wdata_i,
  input  logic             msr_re_i,
  input  logic             cts_i,
  input  logic             dsr_i,
  input  logic             ri_i,
  input  logic             dcd_i,
  output logic [REG_W-1:0] mcr_o,
  output logic [REG_W-1:0] msr_rdata_o,
  output logic             dtr_o,
  output logic             rts_o,
  output logic             out1_o,
  output logic             out2_o,
  output logic             msi_o
);
  logic [PIN_N-1:0] pin_raw, pin_sts, pin_prev, ev_set, ev_flag;
  logic [REG_W-1:0] mcr_q;
  logic             loop_en, flag_clr;

  assign pin_raw = {dcd_i, ri_i, dsr_i, cts_i};

  modem_mcr #(.REG_W(REG_W), .KEEP_W(MCR_W), .RST_VAL(MCR_RST)) u_mcr (
    .clk_i, .rst_ni, .we_i(mcr_we_i), .wdata_i(mcr_wdata_i), .mcr_o(mcr_q)
  );

  modem_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_raw), .q_o(pin_sts)
  );

  assign loop_en  = mcr_q[LOOP_BIT];
  assign flag_clr = msr_re_i & ~loop_en;

  modem_delta #(.W(PIN_N), .RST_VAL(PIN_RST), .FALL_MSK(FALL_MSK)) u_delta (
    .clk_i, .rst_ni, .sts_i(pin_sts), .clr_i(flag_clr),
    .prev_o(pin_prev), .set_o(ev_set), .flag_o(ev_flag)
  );

  always_comb begin
    if (loop_en) begin
      msr_rdata_o = '0;
      msr_rdata_o[PIN_N+IDX_DCD] = mcr_q[3];
      msr_rdata_o[PIN_N+IDX_RI]  = mcr_q[2];
      msr_rdata_o[PIN_N+IDX_DSR] = mcr_q[0];
      msr_rdata_o[PIN_N+IDX_CTS] = mcr_q[1];
    end else begin
      msr_rdata_o = {pin_sts, ev_flag};
    end
  end

  assign mcr_o  = mcr_q;
  assign dtr_o  = mcr_q[0];
  assign rts_o  = mcr_q[1];
  assign out1_o = mcr_q[2];
  assign out2_o = mcr_q[3];
  assign msi_o  = |ev_flag;
endmodule

// File: rtl/modem_ctl_stat_chk.sv
module modem_ctl_stat_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       msr_re_i,
  input logic [7:0] mcr_o,
  input logic [7:0] msr_rdata_o,
  input logic       msi_o,
  input logic [3:0] pin_sts,
  input logic [3:0] pin_prev,
  input logic [3:0] ev_set,
  input logic [3:0] ev_flag
);
  // R2
  mcr_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_o[7:5] == 3'b000);

  // R9
  loop_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr_o[4] |-> (msr_rdata_o == {mcr_o[3], mcr_o[2], mcr_o[0], mcr_o[1], 4'b0000}));

  // R11
  msi_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mcr_o[4] |-> (msi_o == (msr_rdata_o[3:0] != 4'b0000)));

  // R7
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_re_i && !mcr_o[4]) |=> ((ev_flag & ~$past(ev_set)) == 4'b0000));

  // R6
  ri_fall_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ev_flag[2]) |-> $past(pin_prev[2] && !pin_sts[2]));
endmodule

bind modem_ctl_stat modem_ctl_stat_chk u_chk (
  .clk_i, .rst_ni, .msr_re_i, .mcr_o, .msr_rdata_o, .msi_o,
  .pin_sts, .pin_prev, .ev_set, .ev_flag
);

// File: tb/tb_modem_ctl_stat.sv
module tb_modem_ctl_stat;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic mcr_we_i = 1'b0, msr_re_i = 1'b0;
  logic [7:0] mcr_wdata_i = '0;
  logic cts_i = 1'b1, dsr_i = 1'b1, ri_i = 1'b0, dcd_i = 1'b1;
  logic [7:0] mcr_o, msr_rdata_o;
  logic dtr_o, rts_o, out1_o, out2_o, msi_o;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;
  logic [3:0] e_pin = 4'b1011, e_flag = 4'b0000;
  logic [7:0] e_mcr = 8'h08;

  modem_ctl_stat dut (.*);

  always #4 clk_i = ~clk_i;

  function automatic logic [7:0] loop_val(input logic [7:0] m);
    return {m[3], m[2], m[0], m[1], 4'b0000};
  endfunction

  function automatic logic [3:0] new_flags(input logic [3:0] o, input logic [3:0] n);
    logic [3:0] f;
    f = o ^ n;
    f[2] = o[2] & ~n[2];
    return f;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic set_pins(input logic [3:0] p);
    {dcd_i, ri_i, dsr_i, cts_i} = p;
  endtask

  task automatic wr_mcr(input logic [7:0] v);
    mcr_wdata_i = v; mcr_we_i = 1'b1;
    step(1);
    mcr_we_i = 1'b0;
    e_mcr = {3'b000, v[4:0]};
  endtask

  task automatic chk_all(input string req);
    chk({req, " mcr"}, mcr_o, e_mcr);
    chk({req, " pins"}, {4'b0, out2_o, out1_o, rts_o, dtr_o}, {4'b0, e_mcr[3:0]});
    chk({req, " msr"}, msr_rdata_o, e_mcr[4] ? loop_val(e_mcr) : {e_pin, e_flag});
    chk({req, " msi"}, {7'b0, msi_o}, {7'b0, |e_flag});
  endtask

  task automatic rd_msr(input string req);
    msr_re_i = 1'b1;
    #1 chk(req, msr_rdata_o, e_mcr[4] ? loop_val(e_mcr) : {e_pin, e_flag});
    step(1);
    msr_re_i = 1'b0;
    if (!e_mcr[4]) e_flag = 4'b0000;
  endtask

  task automatic move_pins(input logic [3:0] p);
    set_pins(p);
    step(3);
    e_flag = e_flag | new_flags(e_pin, p);
    e_pin = p;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    step(2);
    rst_ni = 1'b1;
    step(1);
    // R1 reset values
    #1 chk("R1 mcr", mcr_o, 8'h08);
    chk("R1 msr", msr_rdata_o, 8'hB0);
    chk("R1 outs", {4'b0, out2_o, out1_o, rts_o, dtr_o}, 8'h08);
    chk("R1 msi", {7'b0, msi_o}, 8'h00);

    // R2 R3 upper bits dropped, outputs follow
    wr_mcr(8'hE7);
    #1 chk("R2 mcr mask", mcr_o, 8'h07);
    chk("R3 outs", {4'b0, out2_o, out1_o, rts_o, dtr_o}, 8'h07);
    wr_mcr(8'h00);

    // R4 R5 latency: cts drops
    set_pins(4'b1010);
    step(1);
    #1 chk("R4 not yet", msr_rdata_o, 8'hB0);
    step(1);
    #1 chk("R4 status after 2 edges", msr_rdata_o, 8'hA0);
    step(1);
    #1 chk("R5 cts flag", msr_rdata_o, 8'hA1);
    chk("R11 msi set", {7'b0, msi_o}, 8'h01);
    e_pin = 4'b1010; e_flag = 4'b0001;
    rd_msr("R7 read value");
    #1 chk("R7 cleared", msr_rdata_o, 8'hA0);
    chk("R11 msi clear", {7'b0, msi_o}, 8'h00);

    // R6 ring: rise no flag, fall flag
    move_pins(4'b1110);
    #1 chk("R6 ri rise", msr_rdata_o, 8'hE0);
    move_pins(4'b1010);
    #1 chk("R6 ri fall", msr_rdata_o, 8'hA4);
    rd_msr("R6 read");

    // R8 collision: dsr flag pending, cts edge lands on read edge
    move_pins(4'b1000);
    set_pins(4'b1001);
    step(2);
    msr_re_i = 1'b1;
    step(1);
    msr_re_i = 1'b0;
    #1 chk("R8 set wins", msr_rdata_o, 8'h91);
    e_pin = 4'b1001; e_flag = 4'b0001;
    rd_msr("R8 read");

    // R9 R10 loopback keeps flags
    move_pins(4'b0001);
    wr_mcr(8'h1A);
    #1 chk("R9 loop map", msr_rdata_o, 8'h90);
    rd_msr("R10 loop read");
    move_pins(4'b0101);
    wr_mcr(8'h05);
    #1 chk("R10 flags kept", msr_rdata_o, 8'h58);
    rd_msr("R10 read");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: move_pins(4'($urandom));
        1: wr_mcr(8'($urandom) & ($urandom_range(0, 2) == 0 ? 8'hFF : 8'hEF));
        2: rd_msr("R7 R10 random read");
        default: step(1);
      endcase
      #1 chk_all("R3 R4 R5 R9 R11 random");
    end

    finish_run();
  end
endmodule